// File: doc/BRIEF.md
# Multicycle Multiply/Divide Unit

This block is a sequential arithmetic engine placed next to a 16-bit ALU. It multiplies two 16-bit words into a 32-bit product, or divides a 32-bit dividend by a 16-bit divisor into a 16-bit quotient and a 16-bit remainder. Both operations work on unsigned or two's-complement operands. The caller presents the operands, the operation select and the signedness flag, then pulses `start` for one cycle. The unit samples the operands only on that cycle.

The latencies are fixed and differ by operation. A multiply always takes five clock cycles and a divide always takes ten. When the operation finishes, the answer lands in two dedicated result words, `res_hi` and `res_lo`, and `done` pulses for one cycle. For a multiply, `res_hi` takes the upper half of the product and `res_lo` the lower half. For a divide, `res_lo` takes the quotient and `res_hi` the remainder.

A zero divisor raises `err_zero`. A quotient that cannot be represented in 16 bits raises `err_ovf`. In both cases the result words keep their previous contents.

Top module: `muldiv_unit`

## Requirements
- R1: With `op_div`=0 and `is_signed`=0, the unit multiplies `opnd_lo` by `opnd_b` as unsigned numbers. Product bits 31:16 go to `res_hi` and bits 15:0 to `res_lo`. `opnd_hi` has no effect on a multiply.
- R2: With `op_div`=0 and `is_signed`=1, both factors are read as two's complement, and the 32-bit two's-complement product goes to `res_hi`/`res_lo`. This holds for the case -32768 times -32768.
- R3: Call the rising edge that accepts `start` edge 0. For a multiply, `busy` is 1 from edge 0 until edge 5, and `done` is 1 in the cycle that follows edge 5.
- R4: With `op_div`=1 and `is_signed`=0, the dividend {`opnd_hi`,`opnd_lo`} is divided by `opnd_b`. The quotient goes to `res_lo` and the remainder to `res_hi`.
- R5: With `op_div`=1 and `is_signed`=1, dividend and divisor are read as two's complement. The quotient is truncated toward zero, and the remainder takes the sign of the dividend.
- R6: For a divide, `busy` is 1 from edge 0 until edge 10, and `done` is 1 in the cycle that follows edge 10.
- R7: A divide by a zero `opnd_b` still completes at edge 10. It sets `err_zero` to 1, clears `err_ovf`, and leaves `res_hi` and `res_lo` unchanged.
- R8: A nonzero-divisor divide can produce a quotient outside 0..65535 (unsigned) or outside -32768..32767 (signed). In that case it sets `err_ovf` to 1, clears `err_zero`, and leaves `res_hi` and `res_lo` unchanged.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored. It produces no extra `done`, and it changes neither the running operation's result nor its latency.
- R10: The operands, `op_div` and `is_signed` are sampled only at edge 0. Changing them while `busy` is 1 does not alter the result.
- R11: After reset, `busy`, `done`, `err_zero` and `err_ovf` are 0, and `res_hi` and `res_lo` are 0.
- R12: `done` lasts exactly one cycle. The result words and the error flags change only at the edge that raises `done`, and they hold until the next completion. A multiply, or a divide that succeeds, clears both flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin an operation |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| is_signed | input | 1 | 1 = operands are two's complement |
| opnd_hi | input | 16 | Upper word of the dividend (divide only) |
| opnd_lo | input | 16 | Lower word of the dividend, or the multiplicand |
| opnd_b | input | 16 | Multiplier or divisor |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: the operation has completed |
| res_hi | output | 16 | Upper product word, or remainder |
| res_lo | output | 16 | Lower product word, or quotient |
| err_zero | output | 1 | The last divide had a zero divisor |
| err_ovf | output | 1 | The last divide's quotient did not fit |

## Verification
The bench builds the unit with the package defaults: a 16-bit word, four multiplier bits retired per step and two quotient bits per step. These defaults give the five- and ten-cycle latencies the requirements fix. At this word size, exact products and quotients can be computed in 64-bit bench arithmetic. That puts every signed boundary within reach: the most negative operand in both operations, the quotient of -32768 that just fits, the +32768 that just overflows, and the most negative dividend that fails the pre-division range test. Operands are also changed mid-operation, and start pulses are sent while the unit is busy, to show that the sampled values and the running count are not disturbed.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;

    localparam int WORD_W        = 16;
    localparam int DWORD_W       = 2 * WORD_W;
    localparam int MUL_STEP_BITS = 4;
    localparam int DIV_STEP_BITS = 2;
    localparam int MUL_STEPS     = WORD_W / MUL_STEP_BITS;
    localparam int DIV_STEPS     = WORD_W / DIV_STEP_BITS;
    // one extra edge to write the product, two extra edges on divide (sign fix + write)
    localparam int MUL_LAT       = MUL_STEPS + 1;
    localparam int DIV_LAT       = DIV_STEPS + 2;
    localparam int CNT_W         = $clog2(DIV_LAT + 1);

    typedef logic [WORD_W-1:0]        word_t;
    typedef logic [DWORD_W-1:0]       dword_t;
    typedef logic [CNT_W-1:0]         cnt_t;
    typedef logic [MUL_STEP_BITS-1:0] digit_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MUL  = 2'd1,
        PH_DIV  = 2'd2
    } phase_e;

    // per-cycle strobes issued by the sequencer
    typedef struct packed {
        logic load;
        logic mul_step;
        logic div_step;
        logic div_fix;
        logic fin_mul;
        logic fin_div;
    } ctl_t;

    // divide outcome after sign correction
    typedef struct packed {
        word_t quo;
        word_t rem;
        logic  zero;
        logic  ovf;
    } div_out_t;

    function automatic word_t mag_w(word_t v, logic sg);
        return (sg && v[WORD_W-1]) ? word_t'(-v) : v;
    endfunction

    function automatic dword_t mag_d(dword_t v, logic sg);
        return (sg && v[DWORD_W-1]) ? dword_t'(-v) : v;
    endfunction

    // sum of the multiplicand shifted by each set bit of one digit
    function automatic dword_t digit_product(dword_t mc, digit_t dig);
        dword_t s;
        s = '0;
        for (int i = 0; i < MUL_STEP_BITS; i++) begin
            if (dig[i]) s = s + (mc << i);
        end
        return s;
    endfunction

endpackage

// File: rtl/md_ctrl.sv
`timescale 1ns/1ps
module md_ctrl
    import muldiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic op_div,
    output logic busy,
    output ctl_t ctl,
    output logic done
);

    localparam cnt_t MUL_LAST = cnt_t'(MUL_STEPS);
    localparam cnt_t MUL_FIN  = cnt_t'(MUL_LAT);
    localparam cnt_t DIV_LAST = cnt_t'(DIV_STEPS);
    localparam cnt_t DIV_FIXC = cnt_t'(DIV_STEPS + 1);
    localparam cnt_t DIV_FIN  = cnt_t'(DIV_LAT);

    phase_e phase;
    cnt_t   cnt;
    logic   accept;
    logic   finish;

    assign accept = start && (phase == PH_IDLE);
    assign busy   = (phase != PH_IDLE);
    assign finish = ctl.fin_mul || ctl.fin_div;

    always_comb begin
        ctl          = '0;
        ctl.load     = accept;
        ctl.mul_step = (phase == PH_MUL) && (cnt <= MUL_LAST);
        ctl.fin_mul  = (phase == PH_MUL) && (cnt == MUL_FIN);
        ctl.div_step = (phase == PH_DIV) && (cnt <= DIV_LAST);
        ctl.div_fix  = (phase == PH_DIV) && (cnt == DIV_FIXC);
        ctl.fin_div  = (phase == PH_DIV) && (cnt == DIV_FIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= finish;
            if (accept) begin
                phase <= op_div ? PH_DIV : PH_MUL;
                cnt   <= cnt_t'(1);
            end else if (finish) begin
                phase <= PH_IDLE;
                cnt   <= '0;
            end else if (phase != PH_IDLE) begin
                cnt <= cnt + cnt_t'(1);
            end
        end
    end

endmodule

// File: rtl/md_mul_core.sv
`timescale 1ns/1ps
module md_mul_core
    import muldiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   step,
    input  logic   sg,
    input  word_t  a,
    input  word_t  b,
    output dword_t product
);

    dword_t acc;
    dword_t mc;
    word_t  mp;
    logic   neg;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            mc  <= '0;
            mp  <= '0;
            neg <= 1'b0;
        end else if (load) begin
            acc <= '0;
            mc  <= dword_t'(mag_w(a, sg));
            mp  <= mag_w(b, sg);
            neg <= sg && (a[WORD_W-1] ^ b[WORD_W-1]);
        end else if (step) begin
            acc <= acc + digit_product(mc, mp[MUL_STEP_BITS-1:0]);
            mc  <= mc << MUL_STEP_BITS;
            mp  <= mp >> MUL_STEP_BITS;
        end
    end

    assign product = neg ? dword_t'(-acc) : acc;

endmodule

// File: rtl/md_div_core.sv
`timescale 1ns/1ps
module md_div_core
    import muldiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     step,
    input  logic     fix,
    input  logic     sg,
    input  dword_t   dividend,
    input  word_t    divisor,
    output div_out_t res
);

    word_t  rem_q;
    word_t  quo_q;
    word_t  dvs_q;
    logic   zero_q;
    logic   povf_q;
    logic   negq_q;
    logic   negr_q;
    logic   sg_q;
    dword_t dmag;
    word_t  bmag;
    logic   range_bad;

    assign dmag = mag_d(dividend, sg);
    assign bmag = mag_w(divisor, sg);

    // chained restoring stages, DIV_STEP_BITS quotient bits per clock
    word_t ch_rem [DIV_STEP_BITS+1];
    word_t ch_quo [DIV_STEP_BITS+1];

    assign ch_rem[0] = rem_q;
    assign ch_quo[0] = quo_q;

    for (genvar k = 0; k < DIV_STEP_BITS; k++) begin : g_stage
        logic [WORD_W:0] trial;
        logic [WORD_W:0] diff;
        logic            fits;
        assign trial         = {ch_rem[k], ch_quo[k][WORD_W-1]};
        assign diff          = trial - {1'b0, dvs_q};
        assign fits          = (trial >= {1'b0, dvs_q});
        assign ch_rem[k+1]   = fits ? diff[WORD_W-1:0] : trial[WORD_W-1:0];
        assign ch_quo[k+1]   = {ch_quo[k][WORD_W-2:0], fits};
    end

    // signed range: magnitude 2^(W-1) fits only when the quotient is negative
    assign range_bad = quo_q[WORD_W-1] && (!negq_q || (|quo_q[WORD_W-2:0]));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            zero_q <= 1'b0;
            povf_q <= 1'b0;
            negq_q <= 1'b0;
            negr_q <= 1'b0;
            sg_q   <= 1'b0;
            res    <= '0;
        end else if (load) begin
            rem_q  <= dmag[DWORD_W-1:WORD_W];
            quo_q  <= dmag[WORD_W-1:0];
            dvs_q  <= bmag;
            zero_q <= (divisor == '0);
            povf_q <= (divisor != '0) && (dmag[DWORD_W-1:WORD_W] >= bmag);
            negq_q <= sg && (dividend[DWORD_W-1] ^ divisor[WORD_W-1]);
            negr_q <= sg && dividend[DWORD_W-1];
            sg_q   <= sg;
        end else if (step) begin
            rem_q <= ch_rem[DIV_STEP_BITS];
            quo_q <= ch_quo[DIV_STEP_BITS];
        end else if (fix) begin
            res.quo  <= negq_q ? word_t'(-quo_q) : quo_q;
            res.rem  <= negr_q ? word_t'(-rem_q) : rem_q;
            res.zero <= zero_q;
            res.ovf  <= !zero_q && (povf_q || (sg_q && range_bad));
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit
    import muldiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  op_div,
    input  logic  is_signed,
    input  word_t opnd_hi,
    input  word_t opnd_lo,
    input  word_t opnd_b,
    output logic  busy,
    output logic  done,
    output word_t res_hi,
    output word_t res_lo,
    output logic  err_zero,
    output logic  err_ovf
);

    ctl_t     ctl;
    dword_t   prod;
    div_out_t dres;

    md_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op_div (op_div),
        .busy   (busy),
        .ctl    (ctl),
        .done   (done)
    );

    md_mul_core u_mul (
        .clk     (clk),
        .rst     (rst),
        .load    (ctl.load),
        .step    (ctl.mul_step),
        .sg      (is_signed),
        .a       (opnd_lo),
        .b       (opnd_b),
        .product (prod)
    );

    md_div_core u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .step     (ctl.div_step),
        .fix      (ctl.div_fix),
        .sg       (is_signed),
        .dividend ({opnd_hi, opnd_lo}),
        .divisor  (opnd_b),
        .res      (dres)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_hi   <= '0;
            res_lo   <= '0;
            err_zero <= 1'b0;
            err_ovf  <= 1'b0;
        end else if (ctl.fin_mul) begin
            res_hi   <= prod[DWORD_W-1:WORD_W];
            res_lo   <= prod[WORD_W-1:0];
            err_zero <= 1'b0;
            err_ovf  <= 1'b0;
        end else if (ctl.fin_div) begin
            err_zero <= dres.zero;
            err_ovf  <= dres.ovf;
            if (!dres.zero && !dres.ovf) begin
                res_hi <= dres.rem;
                res_lo <= dres.quo;
            end
        end
    end

endmodule

// File: rtl/md_checker.sv
`timescale 1ns/1ps
module md_checker
    import muldiv_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  start,
    input logic  op_div,
    input logic  busy,
    input logic  done,
    input word_t res_hi,
    input word_t res_lo,
    input logic  err_zero,
    input logic  err_ovf
);

    localparam cnt_t MUL_L = cnt_t'(MUL_LAT);
    localparam cnt_t DIV_L = cnt_t'(DIV_LAT);

    cnt_t lat;
    logic lat_div;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat     <= '0;
            lat_div <= 1'b0;
        end else if (start && !busy) begin
            lat     <= '0;
            lat_div <= op_div;
        end else if (busy) begin
            lat <= lat + cnt_t'(1);
        end
    end

    assert_accept_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_mul_latency_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !lat_div) |-> (lat == MUL_L));

    assert_div_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (done && lat_div) |-> (lat == DIV_L));

    assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (lat < (lat_div ? DIV_L : MUL_L)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_results_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (!$stable(res_hi) || !$stable(res_lo)) |-> done);

    assert_flags_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(err_zero) && $stable(err_ovf)));

    assert_zero_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (done && err_zero) |-> ($stable(res_hi) && $stable(res_lo)));

    assert_ovf_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (done && err_ovf) |-> ($stable(res_hi) && $stable(res_lo)));

    assert_flags_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(err_zero && err_ovf));

endmodule

bind muldiv_unit md_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .op_div   (op_div),
    .busy     (busy),
    .done     (done),
    .res_hi   (res_hi),
    .res_lo   (res_lo),
    .err_zero (err_zero),
    .err_ovf  (err_ovf)
);

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;
    import muldiv_pkg::*;

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  start = 1'b0;
    logic  op_div = 1'b0;
    logic  is_signed = 1'b0;
    word_t opnd_hi = '0;
    word_t opnd_lo = '0;
    word_t opnd_b = '0;
    logic  busy, done, err_zero, err_ovf;
    word_t res_hi, res_lo;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    typedef struct {
        word_t hi;
        word_t lo;
        logic  ez;
        logic  eo;
        int    lat;
        int    c0;
        string tag;
    } exp_t;

    exp_t  sb[$];
    word_t mdl_hi = '0;
    word_t mdl_lo = '0;
    logic  prev_done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    muldiv_unit u0 (
        .clk(clk), .rst(rst), .start(start), .op_div(op_div), .is_signed(is_signed),
        .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .opnd_b(opnd_b),
        .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo),
        .err_zero(err_zero), .err_ovf(err_ovf)
    );

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops an expected item on each completion
    always @(negedge clk) begin : mon
        exp_t e;
        if (!rst && done) begin
            chk("R12", "done width", longint'(prev_done), 0);
            if (sb.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R9 unexpected done actual=1 expected=0");
            end else begin
                e = sb.pop_front();
                chk(e.tag, "res_hi", longint'(res_hi), longint'(e.hi));
                chk(e.tag, "res_lo", longint'(res_lo), longint'(e.lo));
                chk(e.tag, "err_zero", longint'(err_zero), longint'(e.ez));
                chk(e.tag, "err_ovf", longint'(err_ovf), longint'(e.eo));
                chk(e.lat == MUL_LAT ? "R3" : "R6", "latency", longint'(cyc - e.c0), longint'(e.lat));
            end
        end
        prev_done = done;
    end

    // driver: computes the expected outcome, pushes it, pulses start
    task automatic issue(bit dv, bit sg, word_t ahi, word_t alo, word_t b, string tag);
        exp_t   e;
        longint p, dd, bb, q, r;
        e.ez  = 1'b0;
        e.eo  = 1'b0;
        e.tag = tag;
        if (!dv) begin
            e.lat = MUL_LAT;
            if (sg) p = longint'($signed(alo)) * longint'($signed(b));
            else    p = longint'(alo) * longint'(b);
            mdl_hi = p[31:16];
            mdl_lo = p[15:0];
        end else begin
            e.lat = DIV_LAT;
            if (b == '0) begin
                e.ez = 1'b1;
            end else begin
                if (sg) begin
                    dd = longint'($signed({ahi, alo}));
                    bb = longint'($signed(b));
                end else begin
                    dd = longint'({ahi, alo});
                    bb = longint'(b);
                end
                q = dd / bb;
                r = dd % bb;
                if (sg ? (q > 32767 || q < -32768) : (q > 65535)) begin
                    e.eo = 1'b1;
                end else begin
                    mdl_hi = r[15:0];
                    mdl_lo = q[15:0];
                end
            end
        end
        e.hi = mdl_hi;
        e.lo = mdl_lo;
        @(negedge clk);
        op_div = dv; is_signed = sg; opnd_hi = ahi; opnd_lo = alo; opnd_b = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        e.c0 = cyc;
        chk(dv ? "R6" : "R3", "busy after start", longint'(busy), 1);
        sb.push_back(e);
    endtask

    task automatic wait_idle;
        while (busy) @(negedge clk);
    endtask

    task automatic run(bit dv, bit sg, word_t ahi, word_t alo, word_t b, string tag);
        issue(dv, sg, ahi, alo, b, tag);
        wait_idle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", "busy", longint'(busy), 0);
        chk("R11", "done", longint'(done), 0);
        chk("R11", "res_hi", longint'(res_hi), 0);
        chk("R11", "res_lo", longint'(res_lo), 0);
        chk("R11", "err_zero", longint'(err_zero), 0);
        chk("R11", "err_ovf", longint'(err_ovf), 0);

        // R1 unsigned multiply (opnd_hi carries junk)
        run(0, 0, 16'hDEAD, 16'hFFFF, 16'hFFFF, "R1");
        run(0, 0, 16'h1234, 16'd1234, 16'd5678, "R1");
        run(0, 0, 16'hBEEF, 16'h0000, 16'h8001, "R1");
        run(0, 0, 16'h0000, 16'h8000, 16'h8000, "R1");

        // R2 signed multiply
        run(0, 1, 16'h5555, 16'hFFFF, 16'hFFFF, "R2");
        run(0, 1, 16'h0000, 16'h8000, 16'h8000, "R2");
        run(0, 1, 16'h0000, 16'hFFFD, 16'd7, "R2");
        run(0, 1, 16'h0000, 16'h8000, 16'h0001, "R2");
        run(0, 1, 16'h0000, 16'h7FFF, 16'h8000, "R2");

        // R4 unsigned divide
        run(1, 0, 16'h1234, 16'h5678, 16'h5678, "R4");
        run(1, 0, 16'h0000, 16'd100, 16'd7, "R4");
        run(1, 0, 16'h0000, 16'hFFFF, 16'h0001, "R4");
        run(1, 0, 16'hFFFE, 16'hFFFF, 16'hFFFF, "R4");

        // R5 signed divide
        run(1, 1, 16'hFFFF, 16'hFF9C, 16'd7, "R5");
        run(1, 1, 16'h0000, 16'd100, 16'hFFF9, "R5");
        run(1, 1, 16'hFFFF, 16'hFF9C, 16'hFFF9, "R5");
        run(1, 1, 16'hFFFF, 16'h8000, 16'h0001, "R5");
        run(1, 1, 16'h0001, 16'h0000, 16'h8000, "R5");

        // R7 zero divisor, results stay from previous op
        run(1, 0, 16'h1111, 16'h2222, 16'h0000, "R7");
        repeat (3) @(negedge clk);
        chk("R12", "err_zero held", longint'(err_zero), 1);
        run(1, 1, 16'hFFFF, 16'hFFFF, 16'h0000, "R7");
        run(0, 0, 16'h0000, 16'd3, 16'd5, "R12");

        // R8 quotient overflow
        run(1, 0, 16'h0001, 16'h0000, 16'h0001, "R8");
        run(1, 1, 16'hFFFF, 16'h8000, 16'hFFFF, "R8");
        run(1, 1, 16'h8000, 16'h0000, 16'hFFFF, "R8");
        run(1, 1, 16'h0001, 16'h0000, 16'h0002, "R8");
        repeat (3) @(negedge clk);
        chk("R12", "err_ovf held", longint'(err_ovf), 1);
        run(1, 0, 16'h0000, 16'd50, 16'd6, "R12");

        // R10 inputs changed while busy
        issue(0, 0, 16'h0000, 16'd300, 16'd200, "R10");
        opnd_lo = 16'hFFFF; opnd_b = 16'h0007; op_div = 1'b1; is_signed = 1'b1;
        @(negedge clk);
        opnd_hi = 16'h7777; opnd_b = 16'h0000;
        wait_idle();
        issue(1, 1, 16'hFFFF, 16'hFC18, 16'd9, "R10");
        opnd_hi = 16'h0000; opnd_lo = 16'h0001; opnd_b = 16'h0003; op_div = 1'b0; is_signed = 1'b0;
        wait_idle();

        // R9 start while busy is ignored
        issue(0, 0, 16'h0000, 16'd1000, 16'd1000, "R9");
        op_div = 1'b1; opnd_hi = 16'h0000; opnd_lo = 16'd9; opnd_b = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        issue(1, 0, 16'h0000, 16'd1000, 16'd33, "R9");
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (14) @(negedge clk);
        chk("R9", "pending items", longint'(sb.size()), 0);
        chk("R9", "busy after ignored start", longint'(busy), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule